// File: doc/BRIEF.md
# Configurable 16-bit timer/counter

This block is a 16-bit up-counter with two count sources. In timer mode it advances on an instruction-cycle tick that fires once every four system clocks. In counter mode it advances on rising edges of an external clock pin, or on the output of a low-frequency oscillator when that oscillator is enabled. Edges from outside pass through a two-flop synchronizer and an edge detector, and then through a prescaler that divides by 1, 2, 4 or 8. In synchronized external mode each prescaled edge is held until the next instruction tick. In unsynchronized mode it is applied at once, so counting goes on while the sleep input is high.

Software reaches the count through an 8-bit bus. In byte mode, the low and high bytes are read and written directly. In 16-bit mode the high byte goes through a buffer. Reading the low byte captures the live high byte into the buffer. Writing the high byte only fills the buffer, and writing the low byte loads both bytes into the count in one cycle. A rollover from 0xFFFF to 0x0000 sets a sticky overflow flag. When the trigger-select input is high, a pulse from an external compare unit clears the count.

Two small state machines set the timing. The instruction-phase machine steps PH_Q1 → PH_Q2 → PH_Q3 → PH_Q4 → PH_Q1, one step per clock, and raises the tick in PH_Q4 while sleep is low. The synchronizing gate rests in GT_IDLE. It moves GT_IDLE → GT_PEND when a prescaled edge arrives without a tick, and GT_PEND → GT_IDLE when the tick releases the held increment. A counter write, or leaving synchronized external mode, forces it back to GT_IDLE.

Top module: `tmr16_unit`

## Requirements
- R1: With `src_ext`=0 and a 1:1 prescale, the count rises by exactly k over any 4k consecutive clocks that follow a counter write, and it never changes in a cycle without an instruction tick.
- R2: `presc_sel` sets the prescale ratio: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. Over 4·r·k clocks after a write, the internal count rises by k. In external mode, 8 edges at ratio 4 give 2.
- R3: With `src_ext`=1 and `ext_async`=1, each rising edge of the selected source adds one, two clocks after the edge is captured. `lfosc_en`=1 selects `lfosc_out`, and `ext_clk_in` is then ignored.
- R4: With `src_ext`=1 and `ext_async`=0, each prescaled edge adds one, applied only on an instruction tick.
- R5: While `run_en`=0, the count holds.
- R6: A rollover from 0xFFFF to 0x0000 sets `ovf_flag`. The flag stays set until `ovf_clr` is pulsed. If a rollover and `ovf_clr` fall in the same cycle, the flag stays set.
- R7: A `trig_pulse` with `trig_sel`=1 clears the count. With `trig_sel`=0 the pulse has no effect.
- R8: In 16-bit mode (`rw16_mode`=1), `rd_lo` returns the live low byte and latches the live high byte into the buffer. `rd_hi` returns the buffer, not the live high byte.
- R9: In 16-bit mode, `wr_hi` loads only the buffer and leaves the count unchanged. `wr_lo` loads {buffer, data} into the count.
- R10: In byte mode (`rw16_mode`=0), `wr_hi` and `rd_hi` reach the live high byte directly, and the low byte is unaffected.
- R11: Any counter write clears the prescaler's partial count.
- R12: While `sleep`=1, counting stops in internal and synchronized external modes. It continues in unsynchronized external mode.
- R13: In a cycle with a counter write, the write takes precedence over the trigger clear and the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_in | input | 1 | External count clock pin |
| lfosc_out | input | 1 | Low-frequency oscillator output |
| lfosc_en | input | 1 | 1: count source is the oscillator output |
| src_ext | input | 1 | 0: instruction tick, 1: external edges |
| ext_async | input | 1 | 1: external increments skip tick alignment |
| presc_sel | input | 2 | Prescale select (ratio 2^value) |
| run_en | input | 1 | Counter enable |
| rw16_mode | input | 1 | 1: buffered 16-bit access |
| trig_sel | input | 1 | 1: compare trigger clears the count |
| trig_pulse | input | 1 | Special-event pulse from the compare unit |
| sleep | input | 1 | Sleep state |
| wr_lo | input | 1 | Write low byte |
| wr_hi | input | 1 | Write high byte |
| rd_lo | input | 1 | Read low byte |
| rd_hi | input | 1 | Read high byte |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| ovf_clr | input | 1 | Clear overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Some rules are checked by assertions on every cycle:
- the count never changes outside an instruction tick in internal or synchronized external mode, nor during sleep;
- the count holds while disabled, and each step is at most one;
- a rollover sets the flag, and the flag stays set until cleared;
- an enabled trigger clears the count;
- in 16-bit mode, a high write fills only the buffer and a low write loads {buffer, data}.

Other behaviour needs the bench's directed scenarios. These cover the exact increment totals over measured windows for each prescale ratio, the edge counts from each external source, the prescaler clearing on a write, and the buffer returning a stale high byte after the live one has changed. They also cover a flag clear that lands in the same cycle as a rollover.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    // instruction-cycle phase, one step per system clock
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    // synchronized-increment gate
    typedef enum logic {
        GT_IDLE = 1'b0,
        GT_PEND = 1'b1
    } gate_e;
endpackage

// File: rtl/tmr16_phase_gen.sv
module tmr16_phase_gen
    import tmr16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic icyc_tick
);
    phase_e ph_q, ph_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_Q1;
        else        ph_q <= ph_d;
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_Q1: ph_d = PH_Q2;
            PH_Q2: ph_d = PH_Q3;
            PH_Q3: ph_d = PH_Q4;
            PH_Q4: ph_d = PH_Q1;
        endcase
    end

    always_comb begin
        icyc_tick = (ph_q == PH_Q4) && !sleep;
    end
endmodule

// File: rtl/tmr16_ext_front.sv
module tmr16_ext_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_in,
    input  logic lfosc_out,
    input  logic lfosc_en,
    output logic ext_rise
);
    logic               src;
    logic [SYNC_STAGES:0] sync_q;

    always_comb src = lfosc_en ? lfosc_out : ext_clk_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], src};
    end

    always_comb ext_rise = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];
endmodule

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse
);
    localparam int PCNT_W = (1 << SEL_W) - 1;

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W:0]   span;
    logic [PCNT_W-1:0] mask;
    logic              at_top;

    always_comb begin
        span   = (PCNT_W+1)'(1) << sel;
        mask   = PCNT_W'(span - 1'b1);
        at_top = (pcnt_q >= mask);
        pulse  = evt && at_top;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pcnt_q <= '0;
        else if (clr)    pcnt_q <= '0;
        else if (evt)    pcnt_q <= at_top ? '0 : pcnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr16_sync_gate.sv
module tmr16_sync_gate
    import tmr16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run_en,
    input  logic src_ext,
    input  logic ext_async,
    input  logic presc_pulse,
    input  logic icyc_tick,
    output logic inc_en
);
    gate_e st_q, st_d;
    logic  sync_mode;

    always_comb sync_mode = src_ext && !ext_async;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GT_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (clr || !sync_mode) begin
            st_d = GT_IDLE;
        end else begin
            unique case (st_q)
                GT_IDLE: if (presc_pulse && !icyc_tick) st_d = GT_PEND;
                GT_PEND: if (icyc_tick && run_en && !presc_pulse) st_d = GT_IDLE;
            endcase
        end
    end

    always_comb begin
        inc_en = 1'b0;
        if (run_en) begin
            if (!sync_mode) begin
                inc_en = presc_pulse;
            end else begin
                unique case (st_q)
                    GT_IDLE: inc_en = presc_pulse && icyc_tick;
                    GT_PEND: inc_en = icyc_tick;
                endcase
            end
        end
    end
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit #(
    parameter int BUS_W       = 8,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_in,
    input  logic             lfosc_out,
    input  logic             lfosc_en,
    input  logic             src_ext,
    input  logic             ext_async,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             run_en,
    input  logic             rw16_mode,
    input  logic             trig_sel,
    input  logic             trig_pulse,
    input  logic             sleep,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             rd_lo,
    input  logic             rd_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             ovf_clr,
    output logic             ovf_flag
);
    localparam int CNT_W = 2 * BUS_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             icyc_tick;
    logic             ext_rise;
    logic             evt;
    logic             presc_pulse;
    logic             inc_en;
    logic             any_wr;
    logic             trig_clr;
    logic             rollover;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [BUS_W-1:0] hi_buf_q;
    logic             ovf_q;

    tmr16_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .icyc_tick (icyc_tick)
    );

    tmr16_ext_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_clk_in (ext_clk_in),
        .lfosc_out  (lfosc_out),
        .lfosc_en   (lfosc_en),
        .ext_rise   (ext_rise)
    );

    always_comb begin
        any_wr   = wr_lo || wr_hi;
        trig_clr = trig_sel && trig_pulse;
        evt      = run_en && (src_ext ? ext_rise : icyc_tick);
    end

    tmr16_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (any_wr),
        .evt   (evt),
        .sel   (presc_sel),
        .pulse (presc_pulse)
    );

    tmr16_sync_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (any_wr),
        .run_en      (run_en),
        .src_ext     (src_ext),
        .ext_async   (ext_async),
        .presc_pulse (presc_pulse),
        .icyc_tick   (icyc_tick),
        .inc_en      (inc_en)
    );

    // next count: write > trigger clear > increment
    always_comb begin
        cnt_d    = cnt_q;
        rollover = 1'b0;
        if (any_wr) begin
            if (rw16_mode) begin
                if (wr_lo) cnt_d = {hi_buf_q, wdata};
            end else begin
                if (wr_lo) cnt_d[BUS_W-1:0]     = wdata;
                if (wr_hi) cnt_d[CNT_W-1:BUS_W] = wdata;
            end
        end else if (trig_clr) begin
            cnt_d = '0;
        end else if (inc_en) begin
            cnt_d    = cnt_q + 1'b1;
            rollover = (cnt_q == CNT_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hi_buf_q <= '0;
        else if (rw16_mode && wr_hi) hi_buf_q <= wdata;
        else if (rw16_mode && rd_lo) hi_buf_q <= cnt_q[CNT_W-1:BUS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (rollover) ovf_q <= 1'b1;
        else if (ovf_clr)  ovf_q <= 1'b0;
    end

    always_comb begin
        ovf_flag = ovf_q;
        if (rd_hi)      rdata = rw16_mode ? hi_buf_q : cnt_q[CNT_W-1:BUS_W];
        else if (rd_lo) rdata = cnt_q[BUS_W-1:0];
        else            rdata = '0;
    end
endmodule

// File: rtl/tmr16_unit_chk.sv
module tmr16_unit_chk #(
    parameter int BUS_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_en,
    input logic               src_ext,
    input logic               ext_async,
    input logic               sleep,
    input logic               rw16_mode,
    input logic               trig_sel,
    input logic               trig_pulse,
    input logic               wr_lo,
    input logic               wr_hi,
    input logic [BUS_W-1:0]   wdata,
    input logic               ovf_clr,
    input logic               ovf_flag,
    input logic [2*BUS_W-1:0] cnt_q,
    input logic [BUS_W-1:0]   hi_buf_q,
    input logic               icyc_tick,
    input logic               inc_en
);
    logic quiet;
    always_comb quiet = !wr_lo && !wr_hi && !(trig_sel && trig_pulse);

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R1
    AST_INT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !src_ext && !icyc_tick) |=> cnt_q == $past(cnt_q)); // R1
    AST_SYNC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && src_ext && !ext_async && !icyc_tick) |=> cnt_q == $past(cnt_q)); // R4
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !run_en) |=> cnt_q == $past(cnt_q)); // R5
    AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && inc_en && cnt_q == '1) |=> ovf_flag); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag); // R6
    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel && trig_pulse && !wr_lo && !wr_hi) |=> cnt_q == '0); // R7
    AST_HI_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rw16_mode && wr_hi) |=> hi_buf_q == $past(wdata)); // R9
    AST_HI_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rw16_mode && wr_hi && !wr_lo) |=> cnt_q == $past(cnt_q)); // R9
    AST_LO_LOADS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (rw16_mode && wr_lo) |=> cnt_q == {$past(hi_buf_q), $past(wdata)}); // R9
    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && sleep && !(src_ext && ext_async)) |=> cnt_q == $past(cnt_q)); // R12
endmodule

bind tmr16_unit tmr16_unit_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .src_ext    (src_ext),
    .ext_async  (ext_async),
    .sleep      (sleep),
    .rw16_mode  (rw16_mode),
    .trig_sel   (trig_sel),
    .trig_pulse (trig_pulse),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .wdata      (wdata),
    .ovf_clr    (ovf_clr),
    .ovf_flag   (ovf_flag),
    .cnt_q      (cnt_q),
    .hi_buf_q   (hi_buf_q),
    .icyc_tick  (icyc_tick),
    .inc_en     (inc_en)
);

// File: tb/tmr16_unit_bench.sv
module tmr16_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_in = 0, lfosc_out = 0, lfosc_en = 0;
    logic       src_ext = 0, ext_async = 0, run_en = 0, rw16_mode = 1;
    logic [1:0] presc_sel = 0;
    logic       trig_sel = 0, trig_pulse = 0, sleep = 0;
    logic       wr_lo = 0, wr_hi = 0, rd_lo = 0, rd_hi = 0, ovf_clr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       ovf_flag;
    int         total = 0;
    int         bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    tmr16_unit u_tmr16_unit (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .lfosc_out(lfosc_out),
        .lfosc_en(lfosc_en), .src_ext(src_ext), .ext_async(ext_async),
        .presc_sel(presc_sel), .run_en(run_en), .rw16_mode(rw16_mode),
        .trig_sel(trig_sel), .trig_pulse(trig_pulse), .sleep(sleep),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .wdata(wdata), .rdata(rdata), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic s_ext, input logic asyn, input logic [1:0] ps, input logic run);
        src_ext = s_ext; ext_async = asyn; presc_sel = ps; run_en = run;
    endtask

    // 16-bit write: high byte into buffer, then low byte loads both
    task automatic wr16(input logic [15:0] v);
        rw16_mode = 1; wr_hi = 1; wdata = v[15:8];
        @(negedge clk);
        wr_hi = 0; wr_lo = 1; wdata = v[7:0];
        @(negedge clk);
        wr_lo = 0;
    endtask

    task automatic rd16(output logic [15:0] v);
        rw16_mode = 1; rd_lo = 1;
        #1 v[7:0] = rdata;
        @(negedge clk);
        rd_lo = 0; rd_hi = 1;
        #1 v[15:8] = rdata;
        @(negedge clk);
        rd_hi = 0;
    endtask

    task automatic ext_edges(input int n, input logic use_osc);
        for (int i = 0; i < n; i++) begin
            if (use_osc) lfosc_out = 1; else ext_clk_in = 1;
            cyc(8);
            if (use_osc) lfosc_out = 0; else ext_clk_in = 0;
            cyc(8);
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R6 flag clear after reset", ovf_flag, 0);
        rd16(v);
        chk("R5 count zero after reset", v, 16'h0000);
    endtask

    task automatic t_internal_rate;
        logic [15:0] v;
        cfg(0, 0, 2'd0, 1);
        wr16(16'h0000); cyc(40); rd16(v);
        chk("R1 internal 40 clocks", v, 10);
    endtask

    task automatic t_prescale;
        logic [15:0] v;
        cfg(0, 0, 2'd1, 1); wr16(0); cyc(80); rd16(v);
        chk("R2 ratio 2", v, 10);
        cfg(0, 0, 2'd2, 1); wr16(0); cyc(64); rd16(v);
        chk("R2 ratio 4", v, 4);
        cfg(0, 0, 2'd3, 1); wr16(0); cyc(96); rd16(v);
        chk("R2 ratio 8", v, 3);
        cfg(1, 1, 2'd2, 1); wr16(0); ext_edges(8, 0); cyc(4); rd16(v);
        chk("R2 external ratio 4", v, 2);
    endtask

    task automatic t_ext_async;
        logic [15:0] v;
        cfg(1, 1, 2'd0, 1); lfosc_en = 0;
        wr16(0); ext_edges(5, 0); cyc(4); rd16(v);
        chk("R3 pin edges", v, 5);
        lfosc_en = 1;
        wr16(0); ext_edges(3, 1); ext_edges(2, 0); cyc(4); rd16(v);
        chk("R3 oscillator edges, pin ignored", v, 3);
        lfosc_en = 0;
    endtask

    task automatic t_ext_sync;
        logic [15:0] v;
        cfg(1, 0, 2'd0, 1);
        wr16(0); ext_edges(5, 0); cyc(8); rd16(v);
        chk("R4 synchronized edges", v, 5);
    endtask

    task automatic t_run_gate;
        logic [15:0] v;
        cfg(0, 0, 2'd0, 0);
        wr16(16'h0100); cyc(40); rd16(v);
        chk("R5 disabled holds", v, 16'h0100);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        cfg(0, 0, 2'd0, 1);
        chk("R6 flag low before rollover", ovf_flag, 0);
        wr16(16'hFFFE); cyc(8);
        run_en = 0; rd16(v);
        chk("R6 wrapped count", v, 16'h0000);
        chk("R6 flag set", ovf_flag, 1);
        cyc(20);
        chk("R6 flag sticky", ovf_flag, 1);
        ovf_clr = 1; cyc(1); ovf_clr = 0; #1;
        chk("R6 flag cleared", ovf_flag, 0);
        cfg(1, 1, 2'd0, 1);
        wr16(16'hFFFF);
        ext_clk_in = 1; cyc(2);
        ovf_clr = 1; cyc(1); ovf_clr = 0; #1;
        chk("R6 rollover beats clear", ovf_flag, 1);
        ext_clk_in = 0; cyc(2); rd16(v);
        chk("R6 count wrapped by edge", v, 16'h0000);
        ovf_clr = 1; cyc(1); ovf_clr = 0;
    endtask

    task automatic t_trigger;
        logic [15:0] v;
        cfg(0, 0, 2'd0, 0);
        trig_sel = 1; wr16(16'h4321);
        trig_pulse = 1; cyc(1); trig_pulse = 0; rd16(v);
        chk("R7 trigger clears", v, 0);
        trig_sel = 0; wr16(16'h4321);
        trig_pulse = 1; cyc(1); trig_pulse = 0; rd16(v);
        chk("R7 trigger ignored when deselected", v, 16'h4321);
    endtask

    task automatic t_priority;
        logic [15:0] v;
        cfg(0, 0, 2'd0, 0);
        trig_sel = 1; rw16_mode = 0;
        wr_lo = 1; wdata = 8'h55; trig_pulse = 1;
        cyc(1);
        wr_lo = 0; trig_pulse = 0; trig_sel = 0;
        rd16(v);
        chk("R13 write wins over trigger", v, 16'h4355);
    endtask

    task automatic t_read16;
        cfg(0, 0, 2'd0, 0);
        wr16(16'h12FF);
        rd_lo = 1; #1;
        chk("R8 low byte live", rdata, 8'hFF);
        @(negedge clk); rd_lo = 0;
        trig_sel = 1; trig_pulse = 1; cyc(1); trig_pulse = 0; trig_sel = 0;
        rd_hi = 1; #1;
        chk("R8 high byte from buffer", rdata, 8'h12);
        rw16_mode = 0; #1;
        chk("R8 live high differs", rdata, 8'h00);
        @(negedge clk); rd_hi = 0; rw16_mode = 1;
    endtask

    task automatic t_write16;
        logic [15:0] v;
        cfg(0, 0, 2'd0, 0);
        wr16(16'h1234);
        rw16_mode = 1; wr_hi = 1; wdata = 8'hAB; cyc(1); wr_hi = 0;
        rw16_mode = 0; rd_hi = 1; #1;
        chk("R9 high write leaves count", rdata, 8'h12);
        @(negedge clk); rd_hi = 0; rw16_mode = 1;
        wr_lo = 1; wdata = 8'hCD; cyc(1); wr_lo = 0;
        rd16(v);
        chk("R9 low write loads both", v, 16'hABCD);
    endtask

    task automatic t_byte_mode;
        cfg(0, 0, 2'd0, 0);
        wr16(16'h3377);
        rw16_mode = 0; wr_hi = 1; wdata = 8'h9A; cyc(1); wr_hi = 0;
        rd_hi = 1; #1;
        chk("R10 direct high byte", rdata, 8'h9A);
        @(negedge clk); rd_hi = 0; rd_lo = 1; #1;
        chk("R10 low byte untouched", rdata, 8'h77);
        @(negedge clk); rd_lo = 0; rw16_mode = 1;
    endtask

    task automatic t_presc_clear;
        logic [15:0] v;
        cfg(0, 0, 2'd3, 1);
        wr16(0); cyc(20);
        wr16(0); cyc(60); rd16(v);
        chk("R11 write clears prescaler", v, 1);
    endtask

    task automatic t_sleep;
        logic [15:0] v;
        cfg(0, 0, 2'd0, 1); sleep = 1;
        wr16(0); cyc(40); rd16(v);
        chk("R12 internal stops in sleep", v, 0);
        cfg(1, 1, 2'd0, 1);
        wr16(0); ext_edges(4, 0); cyc(4); rd16(v);
        chk("R12 async counts in sleep", v, 4);
        cfg(1, 0, 2'd0, 1);
        wr16(0); ext_edges(4, 0); cyc(8); rd16(v);
        chk("R12 sync stops in sleep", v, 0);
        sleep = 0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(2);
        t_reset();
        t_internal_rate();
        t_prescale();
        t_ext_async();
        t_ext_sync();
        t_run_gate();
        t_overflow();
        t_trigger();
        t_priority();
        t_read16();
        t_write16();
        t_byte_mode();
        t_presc_clear();
        t_sleep();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule